// File: doc/BRIEF.md
# Microsecond Free-Running Timer With Coherent Two-Part Read

This block is a 12-bit up-counter that advances by one on every cycle in which a one-cycle tick strobe is high. The strobe is produced elsewhere at one pulse per microsecond, so the count is always a time in microseconds, modulo 4096. The counter never stops. It rolls from its top value back to zero without raising any flag.

Software reads the count through an 8-bit port in two parts: the low eight bits, then the upper four. Reading the low part also copies the current upper four bits into a holding register. A later read of the upper part returns that copy and not the live count. The two halves therefore always belong to the same instant, even when a carry into bit 8 occurs between the two reads. To measure a duration, software reads the count at the start and at the end of an event and subtracts the two values.

The block also raises two periodic interrupt requests. One follows counter bit 6, giving one request every 128 µs. The other follows counter bit 9, giving one request every 1.024 ms. Each request is a single-cycle pulse that marks the bit changing from 0 to 1.

Top module: `usec_timer`

## Requirements
- R1: The count increases by exactly one on each rising clock edge at which `tick_en` is high, and holds its value on every edge at which `tick_en` is low.
- R2: While `rst_n` is low, the count and the holding register are cleared to zero, and both interrupt outputs are low.
- R3: From 0xFFF, one further tick gives 0x000. Counting then goes on as normal, with no stop and no flag.
- R4: With `rd_sel` = 0, `rd_data` shows count bits [7:0] combinationally. A clock edge with `rd_en` = 1 and `rd_sel` = 0 copies count bits [11:8] into the holding register.
- R5: With `rd_sel` = 1, `rd_data` shows {4'b0000, holding register}. This value does not follow the live count. The holding register changes only on an edge with `rd_en` = 1 and `rd_sel` = 0.
- R6: `irq_fast` is high for exactly one cycle, starting in the cycle after the tick that takes count bit 6 from 0 to 1. When bit 6 goes from 1 to 0, no pulse is produced.
- R7: `irq_slow` behaves in the same way for count bit 9.
- R8: When a low-part read and a tick fall in the same cycle, both the returned low byte and the captured upper nibble come from the count before the increment.
- R9: Take two coherent reads (low part, then upper part). The second value minus the first, modulo 4096, equals the number of ticks applied between the two reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe, one per microsecond; the count advances on it |
| rd_en | input | 1 | Read strobe; when `rd_sel` = 0 it captures the upper nibble |
| rd_sel | input | 1 | Part select: 0 = low byte, 1 = held upper nibble |
| rd_data | output | 8 | Read data for the selected part (combinational) |
| irq_fast | output | 1 | One-cycle pulse when count bit 6 rises |
| irq_slow | output | 1 | One-cycle pulse when count bit 9 rises |

## Verification
The count is driven with gaps of idle cycles, with runs of back-to-back ticks, and across the carries into bit 6, bit 9 and bit 8. These patterns separate a counter that moves only on the strobe from one that free-runs, and a rising-edge pulse from a level or from a pulse on either edge. A low-part read placed just before a carry into bit 8, followed by an upper-part read, shows whether the upper part comes from the held copy or from the live count. A read that coincides with a tick shows whether the pre-increment or post-increment value is used. A long run through 0xFFF checks the roll-over, and a pair of readings around 300 ticks checks that subtracting two readings gives the elapsed time.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

   // Part select for the read port
   typedef enum logic {
      PART_LOW  = 1'b0,
      PART_HIGH = 1'b1
   } part_sel_e;

   localparam int unsigned DEF_CNT_W    = 12;
   localparam int unsigned DEF_LOW_W    = 8;
   localparam int unsigned DEF_FAST_TAP = 6;
   localparam int unsigned DEF_SLOW_TAP = 9;
   localparam int unsigned IRQ_N        = 2;

endpackage

// File: rtl/utm_counter.sv
module utm_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] count
);

   if (CNT_W < 2) begin : g_bad_width
      $error("utm_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] count_q;

   // Modulo count: the natural overflow gives the roll-over to zero.
   always_ff @(posedge clk) begin
      if (!rst_n)
         count_q <= '0;
      else if (tick_en)
         count_q <= count_q + ONE;
   end

   assign count = count_q;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(count_q)); // R1

   AST_STEP_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> (count_q == $past(count_q) + ONE)); // R3

endmodule

// File: rtl/utm_shadow.sv
module utm_shadow #(
   parameter int unsigned HI_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [HI_W-1:0] live_hi,
   output logic [HI_W-1:0] held_hi
);

   if (HI_W < 1) begin : g_bad_width
      $error("utm_shadow: HI_W must be at least 1");
   end

   logic [HI_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         held_q <= '0;
      else if (capture)
         held_q <= live_hi;
   end

   assign held_hi = held_q;

   AST_CAPTURE_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (held_q == $past(live_hi))); // R8

   AST_HOLD_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(held_q)); // R5

endmodule

// File: rtl/utm_rise_det.sv
module utm_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   output logic pulse
);

   logic last_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         last_q <= 1'b0;
      else
         last_q <= src;
   end

   assign pulse = src & ~last_q;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R6

   AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src) |-> pulse); // R7

   AST_NO_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !src |-> !pulse); // R6

endmodule

// File: rtl/usec_timer.sv
module usec_timer
   import usec_timer_pkg::*;
#(
   parameter int unsigned CNT_W    = DEF_CNT_W,
   parameter int unsigned LOW_W    = DEF_LOW_W,
   parameter int unsigned FAST_TAP = DEF_FAST_TAP,
   parameter int unsigned SLOW_TAP = DEF_SLOW_TAP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             rd_en,
   input  logic             rd_sel,
   output logic [LOW_W-1:0] rd_data,
   output logic             irq_fast,
   output logic             irq_slow
);

   localparam int unsigned HI_W  = CNT_W - LOW_W;
   localparam int unsigned PAD_W = LOW_W - HI_W;

   // Elaboration checks on the parameter set
   if (CNT_W <= LOW_W) begin : g_bad_split
      $error("usec_timer: CNT_W must exceed LOW_W");
   end
   if (HI_W > LOW_W) begin : g_bad_port
      $error("usec_timer: the upper part must fit in the read port");
   end
   if (FAST_TAP >= CNT_W || SLOW_TAP >= CNT_W) begin : g_bad_tap
      $error("usec_timer: interrupt taps must lie inside the counter");
   end
   if (FAST_TAP >= SLOW_TAP) begin : g_bad_order
      $error("usec_timer: fast tap must be below slow tap");
   end

   logic [CNT_W-1:0] count;
   logic [HI_W-1:0]  held_hi;
   logic             cap_low;
   logic [IRQ_N-1:0] irq_vec;
   part_sel_e        part;

   localparam int unsigned TAP_POS [IRQ_N] = '{FAST_TAP, SLOW_TAP};

   assign part    = part_sel_e'(rd_sel);
   assign cap_low = rd_en && (part == PART_LOW);

   utm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .count   (count)
   );

   utm_shadow #(.HI_W(HI_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (cap_low),
      .live_hi (count[CNT_W-1:LOW_W]),
      .held_hi (held_hi)
   );

   for (genvar g = 0; g < IRQ_N; g++) begin : g_tap
      utm_rise_det u_rise (
         .clk   (clk),
         .rst_n (rst_n),
         .src   (count[TAP_POS[g]]),
         .pulse (irq_vec[g])
      );
   end

   // Read mux: the high part gets zero padding only when it is narrower
   // than the port.
   if (PAD_W > 0) begin : g_pad
      always_comb begin
         if (part == PART_HIGH)
            rd_data = {{PAD_W{1'b0}}, held_hi};
         else
            rd_data = count[LOW_W-1:0];
      end
   end else begin : g_nopad
      always_comb begin
         if (part == PART_HIGH)
            rd_data = held_hi;
         else
            rd_data = count[LOW_W-1:0];
      end
   end

   assign irq_fast = irq_vec[0];
   assign irq_slow = irq_vec[1];

   AST_IRQ_NOT_BOTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick_en) |-> !(irq_fast || irq_slow)); // R6

endmodule

// File: tb/sim_usec_timer.sv
module sim_usec_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       rd_en = 1'b0;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic       irq_fast;
   logic       irq_slow;

   int n_cmp = 0;
   int n_bad = 0;
   int model = 0;

   always #4 clk = ~clk;

   usec_timer u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .rd_en    (rd_en),
      .rd_sel   (rd_sel),
      .rd_data  (rd_data),
      .irq_fast (irq_fast),
      .irq_slow (irq_slow)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One tick; the pulses are checked against the model (R6, R7).
   task automatic do_tick();
      int old;
      old = model;
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      model = (model + 1) & 12'hFFF;
      chk("R6 irq_fast", int'(irq_fast), int'(!old[6] && model[6]));
      chk("R7 irq_slow", int'(irq_slow), int'(!old[9] && model[9]));
   endtask

   task automatic tick_to(input int target);
      while (model != target) do_tick();
   endtask

   task automatic read_low(output int v);
      rd_en = 1'b1; rd_sel = 1'b0;
      #1 v = int'(rd_data);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic read_high(output int v);
      rd_sel = 1'b1;
      #1 v = int'(rd_data);
      @(negedge clk);
      rd_sel = 1'b0;
   endtask

   task automatic t_reset();
      int v;
      chk("R2 irq_fast at reset", int'(irq_fast), 0);
      chk("R2 irq_slow at reset", int'(irq_slow), 0);
      read_low(v);  chk("R2 low byte at reset", v, 0);
      read_high(v); chk("R2 held nibble at reset", v, 0);
   endtask

   task automatic t_step();
      int v;
      repeat (5) @(negedge clk);
      read_low(v); chk("R1 no tick, no change", v, 0);
      repeat (3) do_tick();
      repeat (4) @(negedge clk);
      read_low(v); chk("R1 three ticks", v, 3);
   endtask

   task automatic t_fast();
      tick_to(64);
      chk("R6 pulse at 64", int'(irq_fast), 1);
      @(negedge clk);
      chk("R6 pulse lasts one cycle", int'(irq_fast), 0);
      tick_to(128);
      chk("R6 no pulse on fall", int'(irq_fast), 0);
      tick_to(192);
      chk("R6 pulse at 192", int'(irq_fast), 1);
   endtask

   task automatic t_slow();
      tick_to(512);
      chk("R7 pulse at 512", int'(irq_slow), 1);
      @(negedge clk);
      chk("R7 pulse lasts one cycle", int'(irq_slow), 0);
   endtask

   task automatic t_coherent();
      int v;
      tick_to(12'h2FF);
      read_low(v);  chk("R4 low byte", v, 8'hFF);
      do_tick();
      read_high(v); chk("R5 held not live", v, 2);
      read_low(v);  chk("R4 low after carry", v, 0);
      read_high(v); chk("R4 new capture", v, 3);
   endtask

   task automatic t_same_cycle();
      int v;
      tick_to(12'h3FF);
      rd_en = 1'b1; rd_sel = 1'b0; tick_en = 1'b1;
      #1 v = int'(rd_data);
      @(negedge clk);
      rd_en = 1'b0; tick_en = 1'b0;
      model = (model + 1) & 12'hFFF;
      chk("R8 low byte pre-increment", v, 8'hFF);
      read_high(v); chk("R8 nibble pre-increment", v, 3);
      read_low(v);  chk("R8 count advanced", v, 0);
   endtask

   task automatic t_elapsed();
      int lo, hi, a, b;
      read_low(lo); read_high(hi); a = (hi << 8) | lo;
      repeat (300) do_tick();
      read_low(lo); read_high(hi); b = (hi << 8) | lo;
      chk("R9 elapsed ticks", (b - a) & 12'hFFF, 300);
   endtask

   task automatic t_wrap();
      int v;
      tick_to(12'hFFF);
      read_low(v);  chk("R3 top low", v, 8'hFF);
      read_high(v); chk("R3 top high", v, 4'hF);
      do_tick();
      read_low(v);  chk("R3 wrapped low", v, 0);
      read_high(v); chk("R3 wrapped high", v, 0);
      do_tick();
      read_low(v);  chk("R3 counts on", v, 1);
   endtask

   bit done = 1'b0;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_step();
      t_fast();
      t_slow();
      t_coherent();
      t_same_cycle();
      t_elapsed();
      t_wrap();
      done = 1'b1;
      summary();
   end

endmodule